// File: doc/BRIEF.md
# Partial-Array Self-Refresh Scheduler

This block decides when a pseudo-static DRAM array gets a refresh cycle and which row the cycle touches. Refresh runs only while the chip is not selected. A refresh configuration word sets four things:

- the share of the array that is kept alive: all of it, a half, a quarter, an eighth, or nothing;
- whether that share sits at the low or the high end of the row space;
- one of four temperature settings, which sets the spacing between refresh strobes;
- a deep power-down flag.

Each refresh is a single-cycle strobe on `ref_req`, and `ref_row` carries the row for that cycle. The refreshed row walks through the selected region and wraps back to the start of that region. Deep power-down stops all refresh. When a configuration write brings the block out of deep power-down, `init_busy` stays high for a fixed initialization period, and no refresh is issued until that period ends. A write that only changes the region or the temperature takes effect at once, with no busy period. The parameter `INIT_CYCLES` sets the initialization period in clock cycles; at 200 MHz, 30000 cycles equals 150 µs.

Top module: `psr_refresh_sched`

## Requirements
- R1: `cfg_part` selects how many rows are refreshed, with 2^ROW_W rows in the whole array. The codes are 0 = all rows, 1 = one half, 2 = one quarter and 3 = one eighth. Every row of the selected region is visited exactly once per pass.
- R2: With `cfg_top`=0 the region runs from row 0 upward. With `cfg_top`=1 the region ends at the last row, 2^ROW_W-1. After a configuration write, the first refresh goes to the lowest row of the new region.
- R3: `cfg_temp` picks the spacing between `ref_req` strobes, counted in clock cycles: 0 gives 8×BASE_INTERVAL, 1 gives 4×, 2 gives 2× and 3 gives 1×. After a configuration write, or when the block becomes active again, the first strobe comes exactly one interval later.
- R4: Refreshed rows rise by one per strobe and wrap from the region's last row to its first row. `ref_row` never leaves the region while `ref_req` is high.
- R5: A `cfg_part` value from 4 to 7 selects no rows, and `ref_req` then never asserts.
- R6: While the stored `cfg_deep_off` is 1, `ref_req` stays low and `init_busy` stays low.
- R7: A write with `cfg_deep_off`=0, made while deep power-down is stored, raises `init_busy`. It stays high for exactly INIT_CYCLES cycles, starting in the cycle after the write. `ref_req` stays low during that time.
- R8: A write made while deep power-down is not stored causes no busy period. A newly enlarged region is refreshed right away.
- R9: While `chip_sel` is 1, `ref_req` stays low.
- R10: During reset, `ref_req` and `init_busy` are low. After reset the configuration is all rows, low end, `cfg_temp`=3 and no deep power-down, and the first strobe goes to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel | input | 1 | High while the chip is selected; refresh only runs when low |
| cfg_load | input | 1 | Single-cycle strobe that stores the configuration fields |
| cfg_part | input | 3 | Region size code |
| cfg_top | input | 1 | Region anchor: 0 low end, 1 high end |
| cfg_temp | input | 2 | Temperature setting, 0 coolest to 3 hottest |
| cfg_deep_off | input | 1 | Deep power-down request |
| ref_req | output | 1 | Refresh strobe, one cycle |
| ref_row | output | ROW_W | Row to refresh while `ref_req` is high |
| init_busy | output | 1 | High during initialization after leaving deep power-down |

## Verification
A table of configurations is run one entry after another. The entries cover every region size at both anchors, with the four temperature settings spread across them. For each entry the bench tracks each strobe to the exact cycle, the first row after the write, and the set of rows visited over more than one pass. Comparing the two anchors at the same size shows whether the region offset is right. Comparing temperature settings shows whether the interval table is right, and running more than one pass shows whether wrapping happens at the correct end. Directed runs then cover the quiet cases (the chip selected, the unused size codes, deep power-down), the exact length of the busy period after leaving deep power-down, and an immediate resize with no busy period.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
   localparam logic [2:0] PART_FULL    = 3'd0;
   localparam logic [2:0] PART_HALF    = 3'd1;
   localparam logic [2:0] PART_QUARTER = 3'd2;
   localparam logic [2:0] PART_EIGHTH  = 3'd3;

   typedef struct packed {
      logic       deep_off;
      logic       from_top;
      logic [1:0] temp;
      logic [2:0] part;
   } rcfg_t;

   localparam rcfg_t RCFG_RESET = '{deep_off: 1'b0, from_top: 1'b0,
                                    temp: 2'd3, part: PART_FULL};

   function automatic logic part_empty(input logic [2:0] p);
      return p > PART_EIGHTH;
   endfunction
endpackage

// File: rtl/psr_region.sv
`timescale 1ns/1ps
module psr_region #(
   parameter int ROW_W = 12
) (
   input  psr_pkg::rcfg_t   cfg,
   output logic [ROW_W-1:0] lo_o,
   output logic [ROW_W-1:0] hi_o
);
   logic [ROW_W:0] all_rows, span, lo_w, hi_w;

   assign all_rows = {1'b1, {ROW_W{1'b0}}};
   assign span     = all_rows >> cfg.part[1:0];
   assign lo_w     = cfg.from_top ? (all_rows - span) : '0;
   assign hi_w     = lo_w + span - (ROW_W+1)'(1);
   assign lo_o     = lo_w[ROW_W-1:0];
   assign hi_o     = hi_w[ROW_W-1:0];
endmodule

// File: rtl/psr_tick.sv
`timescale 1ns/1ps
module psr_tick #(
   parameter int BASE_INTERVAL = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] temp,
   output logic       fire
);
   localparam int W = $clog2(BASE_INTERVAL*8 + 1);

   logic [W-1:0] ival_tab [4];
   logic [W-1:0] cnt;

   for (genvar t = 0; t < 4; t++) begin : g_ival
      assign ival_tab[t] = W'(BASE_INTERVAL << (3 - t));
   end

   assign fire = run && (cnt == ival_tab[temp] - W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (fire)  cnt <= '0;
      else            cnt <= cnt + W'(1);
   end

   // R3: the count never reaches the selected interval
   a_r3_cnt_below_ival: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < ival_tab[temp]));
endmodule

// File: rtl/psr_rowseq.sv
`timescale 1ns/1ps
module psr_rowseq #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   input  logic [ROW_W-1:0] lo,
   input  logic [ROW_W-1:0] hi,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (!rst_n)        row <= '0;
      else if (restart)  row <= lo;
      else if (step)     row <= (row == hi) ? lo : row + ROW_W'(1);
   end

   // R4: after a step from the last row, the next row is the first one
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && row == hi) |=> (row == $past(lo)));
endmodule

// File: rtl/psr_init.sv
`timescale 1ns/1ps
module psr_init #(
   parameter int INIT_CYCLES = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic new_deep_off,
   input  logic cur_deep_off,
   output logic busy
);
   localparam int CW = $clog2(INIT_CYCLES + 1);

   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                                  cnt <= '0;
      else if (load && new_deep_off)               cnt <= '0;
      else if (load && cur_deep_off)               cnt <= CW'(INIT_CYCLES);
      else if (busy)                               cnt <= cnt - CW'(1);
   end

   // R7: leaving deep power-down starts initialization
   a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (load && cur_deep_off && !new_deep_off) |=> busy);
   // R8: other writes never start a busy period
   a_r8_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cur_deep_off && !busy) |=> !busy);
endmodule

// File: rtl/psr_refresh_sched.sv
`timescale 1ns/1ps
module psr_refresh_sched #(
   parameter int ROW_W         = 12,
   parameter int BASE_INTERVAL = 1000,
   parameter int INIT_CYCLES   = 30000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_sel,
   input  logic             cfg_load,
   input  logic [2:0]       cfg_part,
   input  logic             cfg_top,
   input  logic [1:0]       cfg_temp,
   input  logic             cfg_deep_off,
   output logic             ref_req,
   output logic [ROW_W-1:0] ref_row,
   output logic             init_busy
);
   import psr_pkg::*;

   if (ROW_W < 3) begin : g_bad_row_w
      $error("ROW_W must be at least 3 so that an eighth is a whole row");
   end
   if (BASE_INTERVAL < 2) begin : g_bad_base
      $error("BASE_INTERVAL must be at least 2");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   rcfg_t            cfg_q, cfg_new;
   logic             load_q;
   logic [ROW_W-1:0] lo, hi, row;
   logic             active, fire;

   assign cfg_new = '{deep_off: cfg_deep_off, from_top: cfg_top,
                      temp: cfg_temp, part: cfg_part};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= RCFG_RESET;
         load_q <= 1'b0;
      end else begin
         if (cfg_load) cfg_q <= cfg_new;
         load_q <= cfg_load;
      end
   end

   psr_region #(.ROW_W(ROW_W)) u_region (
      .cfg(cfg_q), .lo_o(lo), .hi_o(hi));

   assign active = !chip_sel && !cfg_q.deep_off && !part_empty(cfg_q.part)
                   && !init_busy && !cfg_load;

   psr_tick #(.BASE_INTERVAL(BASE_INTERVAL)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(active), .temp(cfg_q.temp), .fire(fire));

   psr_rowseq #(.ROW_W(ROW_W)) u_rowseq (
      .clk(clk), .rst_n(rst_n), .restart(load_q), .step(fire),
      .lo(lo), .hi(hi), .row(row));

   psr_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .load(cfg_load),
      .new_deep_off(cfg_deep_off), .cur_deep_off(cfg_q.deep_off),
      .busy(init_busy));

   assign ref_req = fire;
   assign ref_row = row;

   a_r4_row_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (ref_row >= lo && ref_row <= hi));
   a_r5_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      part_empty(cfg_q.part) |-> !ref_req);
   a_r6_deep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.deep_off |-> (!ref_req && !init_busy));
   a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |-> !ref_req);
   a_r9_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      chip_sel |-> !ref_req);
endmodule

// File: tb/psr_refresh_sched_test.sv
`timescale 1ns/1ps
module psr_refresh_sched_test;
   localparam int RW = 4;
   localparam int BI = 2;
   localparam int IC = 10;

   logic clk = 1'b0, rst_n = 1'b0, chip_sel = 1'b1, cfg_load = 1'b0;
   logic cfg_top = 1'b0, cfg_deep_off = 1'b0;
   logic [2:0] cfg_part = 3'd0;
   logic [1:0] cfg_temp = 2'd3;
   logic ref_req, init_busy;
   logic [RW-1:0] ref_row;

   int total = 0, bad = 0;
   bit done = 0;

   psr_refresh_sched #(.ROW_W(RW), .BASE_INTERVAL(BI), .INIT_CYCLES(IC)) uut (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .cfg_load(cfg_load),
      .cfg_part(cfg_part), .cfg_top(cfg_top), .cfg_temp(cfg_temp),
      .cfg_deep_off(cfg_deep_off), .ref_req(ref_req), .ref_row(ref_row),
      .init_busy(init_busy));

   always #2.5 clk = ~clk;

   typedef struct packed {
      logic [2:0] part;
      logic       top;
      logic [1:0] temp;
      logic [4:0] first;
      logic [4:0] size;
      logic [4:0] ival;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 1'b1, 2'd2, 5'd8,  5'd8,  5'd4},
      '{3'd2, 1'b0, 2'd1, 5'd0,  5'd4,  5'd8},
      '{3'd3, 1'b1, 2'd0, 5'd14, 5'd2,  5'd16},
      '{3'd2, 1'b1, 2'd3, 5'd12, 5'd4,  5'd2},
      '{3'd3, 1'b0, 2'd2, 5'd0,  5'd2,  5'd4},
      '{3'd1, 1'b0, 2'd3, 5'd0,  5'd8,  5'd2},
      '{3'd0, 1'b1, 2'd1, 5'd0,  5'd16, 5'd8},
      '{3'd0, 1'b0, 2'd0, 5'd0,  5'd16, 5'd16}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] p, input logic t, input logic [1:0] tp,
                            input logic d);
      @(negedge clk);
      cfg_part = p; cfg_top = t; cfg_temp = tp; cfg_deep_off = d; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      #1;
   endtask

   // Observe from the current sample point: strobe timing, rows, coverage
   task automatic observe(input int first, input int size, input int ival, input string tag);
      int gap_err = 0, row_err = 0, pulses = 0, first_seen = -1;
      logic [15:0] seen = '0;
      for (int k = 0; k < (size + 2) * ival; k++) begin
         if (ref_req !== (((k + 1) % ival) == 0)) gap_err++;
         if (ref_req === 1'b1) begin
            if (first_seen < 0) first_seen = int'(ref_row);
            if (int'(ref_row) != first + (pulses % size)) row_err++;
            seen[ref_row] = 1'b1;
            pulses++;
         end
         @(negedge clk); #1;
      end
      chk(gap_err == 0, {tag, " R3 interval"}, gap_err, 0);
      chk(first_seen == first, {tag, " R2 first row"}, first_seen, first);
      chk(row_err == 0, {tag, " R4 row order"}, row_err, 0);
      chk($countones(seen) == size, {tag, " R1 rows covered"}, $countones(seen), size);
   endtask

   task automatic quiet(input int n, input string tag);
      int reqs = 0, busys = 0;
      for (int k = 0; k < n; k++) begin
         if (ref_req !== 1'b0) reqs++;
         if (init_busy !== 1'b0) busys++;
         @(negedge clk); #1;
      end
      chk(reqs == 0, {tag, " no strobe"}, reqs, 0);
      chk(busys == 0, {tag, " not busy"}, busys, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      chip_sel = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R10: reset state
      chk(ref_req === 1'b0, "R10 req in reset", int'(ref_req), 0);
      chk(init_busy === 1'b0, "R10 busy in reset", int'(init_busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      observe(0, 16, 2, "R10 defaults");

      // Table walk
      for (int v = 0; v < NV; v++) begin
         write_cfg(VEC[v].part, VEC[v].top, VEC[v].temp, 1'b0);
         observe(int'(VEC[v].first), int'(VEC[v].size), int'(VEC[v].ival),
                 $sformatf("vec%0d", v));
      end

      // R9: chip selected
      write_cfg(3'd0, 1'b0, 2'd3, 1'b0);
      chip_sel = 1'b1;
      quiet(40, "R9 selected");
      chip_sel = 1'b0;

      // R5: empty region codes
      write_cfg(3'd4, 1'b0, 2'd3, 1'b0);
      quiet(40, "R5 code4");
      write_cfg(3'd7, 1'b1, 2'd3, 1'b0);
      quiet(40, "R5 code7");

      // R6: deep power-down
      write_cfg(3'd0, 1'b0, 2'd3, 1'b1);
      quiet(40, "R6 deep");

      // R7: leave deep power-down, busy exactly IC cycles, then refresh
      write_cfg(3'd3, 1'b1, 2'd3, 1'b0);
      begin
         int busy_n = 0, req_n = 0;
         while (init_busy === 1'b1 && busy_n < 1000) begin
            busy_n++;
            if (ref_req !== 1'b0) req_n++;
            @(negedge clk); #1;
         end
         chk(busy_n == IC, "R7 busy length", busy_n, IC);
         chk(req_n == 0, "R7 strobe during busy", req_n, 0);
      end
      observe(14, 2, 2, "R7 after init");

      // R8: enlarge region without deep power-down, no delay
      write_cfg(3'd1, 1'b0, 2'd3, 1'b0);
      chk(init_busy === 1'b0, "R8 no busy", int'(init_busy), 0);
      observe(0, 8, 2, "R8 enlarged");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule